// File: doc/BRIEF.md
# Read-Priority Memory Request Queue

This block sits between a cache and the system bus and holds outgoing memory requests until the bus takes them. It keeps two small in-order queues, one for reads and one for posted writes, and one arbiter picks which queue's head goes onto a single bus request channel. Reads go first because the pipeline waits on them. A write counts as finished as soon as the queue accepts it. To keep writes from waiting forever, the write head is sent when no read is queued or when the write queue is full.

Every read that arrives is looked up in the write queue. If the read's address matches a buffered write, the read never reaches the bus. The newest matching write data comes back on a hit return port in the next cycle. The `CMP_LSB` parameter sets how many low address bits the lookup ignores: 3 compares double-words and 5 compares 32-byte lines.

All request channels use valid/ready and transfer on a cycle where both are high. A requester may drop valid without a transfer. The bus side holds `bus_valid` and its whole payload steady until `bus_ready` is seen. The hit return is a one-cycle pulse with no back-pressure.

Top module: `rdpri_req_queue`

## Requirements
- R1: The read queue holds RQ_DEPTH (default 2) requests. `rd_in_ready` is low exactly when the read queue is full and the incoming address misses the write queue.
- R2: The write queue holds WQ_DEPTH (default 3) entries. `wr_in_ready` is high exactly when the write queue is not full. That handshake is the write's acknowledgement.
- R3: When both queues are non-empty, the write queue is not full and no transfer is stalled, the bus carries the read head (`bus_is_write` = 0).
- R4: The write head is put on the bus when the read queue is empty or the write queue is full, and no stalled transfer is holding the bus.
- R5: A read accepted while its address matches a valid write entry produces `hit_valid` = 1 in the next cycle. `hit_data` then carries the data of the newest matching entry.
- R6: A read that hits is accepted even when the read queue is full, and it is never queued for the bus.
- R7: The address compare ignores address bits [CMP_LSB-1:0]. The default CMP_LSB is 3.
- R8: While `bus_valid` is high and `bus_ready` is low, the next cycle keeps `bus_valid`, `bus_is_write`, `bus_addr` and `bus_wdata` unchanged.
- R9: Each queue sends its requests to the bus in arrival order. A bus write carries the address and data it was accepted with.
- R10: After reset both queues are empty: `bus_valid` = 0, `hit_valid` = 0, and both input ready signals are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_in_valid | input | 1 | Read request valid |
| rd_in_ready | output | 1 | Read request accepted |
| rd_in_addr | input | AW | Read byte address |
| wr_in_valid | input | 1 | Write request valid |
| wr_in_ready | output | 1 | Write request accepted (posted) |
| wr_in_addr | input | AW | Write byte address |
| wr_in_data | input | DW | Write data |
| hit_valid | output | 1 | Read satisfied from the write queue (pulse) |
| hit_data | output | DW | Data returned for a hit |
| bus_valid | output | 1 | Bus request valid |
| bus_ready | input | 1 | Bus accepts the request |
| bus_is_write | output | 1 | 1 = write, 0 = read |
| bus_addr | output | AW | Bus request address |
| bus_wdata | output | DW | Write data on a bus write |

## Verification
The sharpest collision is a read that matches an entry at the same moment that entry leaves for the bus, or at the same moment a new write to the same address is accepted. The lookup sees the queue as it was before that edge. So the draining entry still answers the read, and a write arriving in the same cycle does not. The bench provokes these cases with a small address pool that changes only the low bits, heavy write traffic and phases of mostly stalled bus. A behavioural queue model predicts every ready, bus and hit output and compares them on each cycle.

// File: rtl/rdpri_pkg.sv
package rdpri_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_RD   = 2'd1,
    SRC_WR   = 2'd2
  } src_e;
endpackage

// File: rtl/rdpri_fifo.sv
module rdpri_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             push,
  input  logic [W-1:0]                     push_data,
  input  logic                             pop,
  output logic [W-1:0]                     head_data,
  output logic [$clog2(DEPTH+1)-1:0]       count,
  output logic                             full,
  output logic                             empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wr_ptr] <= push_data;
  end

  assign head_data = mem_q[rd_ptr];
  assign count     = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
endmodule

// File: rtl/rdpri_wbuf.sv
module rdpri_wbuf #(
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int DEPTH   = 3,
  parameter int CMP_LSB = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [AW-1:0]                push_addr,
  input  logic [DW-1:0]                push_data,
  input  logic                         pop,
  output logic [AW-1:0]                head_addr,
  output logic [DW-1:0]                head_data,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  input  logic [AW-1:0]                look_addr,
  output logic                         look_hit,
  output logic [DW-1:0]                look_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (push) wr_ptr <= wrap_inc(wr_ptr);
      if (pop)  rd_ptr <= wrap_inc(rd_ptr);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
    end
  end

  // Walk entries from oldest to newest; the last match seen is the newest.
  logic [PW:0] slot_sum;
  logic [PW-1:0] slot;
  always_comb begin
    look_hit  = 1'b0;
    look_data = '0;
    slot_sum  = '0;
    slot      = '0;
    for (int i = 0; i < DEPTH; i++) begin
      slot_sum = {1'b0, rd_ptr} + (PW+1)'(i);
      if (slot_sum >= (PW+1)'(DEPTH)) slot_sum = slot_sum - (PW+1)'(DEPTH);
      slot = slot_sum[PW-1:0];
      if ((CW'(i) < cnt_q) &&
          (addr_q[slot][AW-1:CMP_LSB] == look_addr[AW-1:CMP_LSB])) begin
        look_hit  = 1'b1;
        look_data = data_q[slot];
      end
    end
  end

  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];
  assign count     = cnt_q;
  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
endmodule

// File: rtl/rdpri_arb.sv
module rdpri_arb
  import rdpri_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_pending,
  input  logic wr_pending,
  input  logic wr_full,
  input  logic bus_ready,
  output src_e sel,
  output logic bus_valid
);
  src_e lock_q;
  src_e pick;

  always_comb begin
    if (wr_pending && (!rd_pending || wr_full)) pick = SRC_WR;
    else if (rd_pending)                        pick = SRC_RD;
    else                                        pick = SRC_NONE;
  end

  assign sel       = (lock_q != SRC_NONE) ? lock_q : pick;
  assign bus_valid = (sel != SRC_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      lock_q <= SRC_NONE;
    else if (bus_valid && !bus_ready) lock_q <= sel;
    else                             lock_q <= SRC_NONE;
  end
endmodule

// File: rtl/rdpri_req_queue.sv
module rdpri_req_queue
  import rdpri_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int RQ_DEPTH = 2,
  parameter int WQ_DEPTH = 3,
  parameter int CMP_LSB  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_in_valid,
  output logic          rd_in_ready,
  input  logic [AW-1:0] rd_in_addr,
  input  logic          wr_in_valid,
  output logic          wr_in_ready,
  input  logic [AW-1:0] wr_in_addr,
  input  logic [DW-1:0] wr_in_data,
  output logic          hit_valid,
  output logic [DW-1:0] hit_data,
  output logic          bus_valid,
  input  logic          bus_ready,
  output logic          bus_is_write,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata
);
  localparam int RCW = $clog2(RQ_DEPTH+1);
  localparam int WCW = $clog2(WQ_DEPTH+1);

  logic           rq_push, rq_pop, rq_full, rq_empty;
  logic [AW-1:0]  rq_head;
  logic [RCW-1:0] rq_count;
  logic           wq_push, wq_pop, wq_full, wq_empty;
  logic [AW-1:0]  wq_head_addr;
  logic [DW-1:0]  wq_head_data;
  logic [WCW-1:0] wq_count;
  logic           rd_hit;
  logic [DW-1:0]  rd_hit_data;
  src_e           sel;
  logic           bus_fire;

  assign rd_in_ready = rd_hit || !rq_full;
  assign rq_push     = rd_in_valid && !rd_hit && !rq_full;
  assign wr_in_ready = !wq_full;
  assign wq_push     = wr_in_valid && !wq_full;
  assign bus_fire    = bus_valid && bus_ready;
  assign rq_pop      = bus_fire && (sel == SRC_RD);
  assign wq_pop      = bus_fire && (sel == SRC_WR);

  rdpri_fifo #(.W(AW), .DEPTH(RQ_DEPTH)) u_rq (
    .clk, .rst_n,
    .push(rq_push), .push_data(rd_in_addr), .pop(rq_pop),
    .head_data(rq_head), .count(rq_count), .full(rq_full), .empty(rq_empty)
  );

  rdpri_wbuf #(.AW(AW), .DW(DW), .DEPTH(WQ_DEPTH), .CMP_LSB(CMP_LSB)) u_wq (
    .clk, .rst_n,
    .push(wq_push), .push_addr(wr_in_addr), .push_data(wr_in_data), .pop(wq_pop),
    .head_addr(wq_head_addr), .head_data(wq_head_data), .count(wq_count),
    .full(wq_full), .empty(wq_empty),
    .look_addr(rd_in_addr), .look_hit(rd_hit), .look_data(rd_hit_data)
  );

  rdpri_arb u_arb (
    .clk, .rst_n,
    .rd_pending(!rq_empty), .wr_pending(!wq_empty), .wr_full(wq_full),
    .bus_ready, .sel, .bus_valid
  );

  assign bus_is_write = (sel == SRC_WR);
  assign bus_addr     = (sel == SRC_WR) ? wq_head_addr : rq_head;
  assign bus_wdata    = (sel == SRC_WR) ? wq_head_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_valid <= 1'b0;
      hit_data  <= '0;
    end else begin
      hit_valid <= rd_in_valid && rd_hit;
      if (rd_in_valid && rd_hit) hit_data <= rd_hit_data;
    end
  end
endmodule

// File: rtl/rdpri_req_queue_chk.sv
module rdpri_req_queue_chk #(
  parameter int AW       = 16,
  parameter int DW       = 32,
  parameter int RQ_DEPTH = 2,
  parameter int WQ_DEPTH = 3
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          rd_in_valid,
  input logic                          rd_in_ready,
  input logic                          wr_in_ready,
  input logic                          hit_valid,
  input logic                          bus_valid,
  input logic                          bus_ready,
  input logic                          bus_is_write,
  input logic [AW-1:0]                 bus_addr,
  input logic [DW-1:0]                 bus_wdata,
  input logic                          rd_hit,
  input logic [$clog2(RQ_DEPTH+1)-1:0] rq_count,
  input logic [$clog2(WQ_DEPTH+1)-1:0] wq_count
);
  localparam int RCW = $clog2(RQ_DEPTH+1);
  localparam int WCW = $clog2(WQ_DEPTH+1);

  a_r1_rq_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rq_count <= RCW'(RQ_DEPTH));

  a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (wq_count == WCW'(WQ_DEPTH)) |-> !wr_in_ready);

  a_r3_read_first: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_is_write && rq_count != '0 && wq_count != WCW'(WQ_DEPTH))
      |-> $past(bus_valid && !bus_ready && bus_is_write));

  a_r4_full_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (wq_count == WCW'(WQ_DEPTH) && !$past(bus_valid && !bus_ready))
      |-> (bus_valid && bus_is_write));

  a_r5_hit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in_valid && rd_hit) |=> hit_valid);

  a_r6_hit_not_queued: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_in_valid && rd_hit && rd_in_ready) |=> (rq_count <= $past(rq_count)));

  a_r8_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_is_write) && $stable(bus_addr) && $stable(bus_wdata)));
endmodule

bind rdpri_req_queue rdpri_req_queue_chk #(
  .AW(AW), .DW(DW), .RQ_DEPTH(RQ_DEPTH), .WQ_DEPTH(WQ_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_in_valid(rd_in_valid), .rd_in_ready(rd_in_ready),
  .wr_in_ready(wr_in_ready), .hit_valid(hit_valid), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_is_write(bus_is_write), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rd_hit(rd_hit), .rq_count(rq_count), .wq_count(wq_count)
);

// File: tb/tb_rdpri_req_queue.sv
module tb_rdpri_req_queue;
  localparam int AW = 16, DW = 32, RQD = 2, WQD = 3, LSB = 3;
  localparam int NCYC = 6000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_in_valid = 1'b0, rd_in_ready;
  logic [AW-1:0] rd_in_addr = '0;
  logic wr_in_valid = 1'b0, wr_in_ready;
  logic [AW-1:0] wr_in_addr = '0;
  logic [DW-1:0] wr_in_data = '0;
  logic hit_valid;
  logic [DW-1:0] hit_data;
  logic bus_valid, bus_ready = 1'b0, bus_is_write;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;

  always #5 clk = ~clk;

  rdpri_req_queue #(.AW(AW), .DW(DW), .RQ_DEPTH(RQD), .WQ_DEPTH(WQD), .CMP_LSB(LSB)) dut (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [AW-1:0] m_rq[$];
  logic [AW-1:0] m_wa[$];
  logic [DW-1:0] m_wd[$];
  int m_lock = 0;           // 0 none, 1 read, 2 write
  logic m_hv = 1'b0;
  logic [DW-1:0] m_hd = '0;

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] gen_addr();
    logic [AW-1:0] a;
    a = AW'((($urandom % 4) << LSB) | ($urandom % 8));
    if ($urandom % 4 == 0) a = a | 16'h0100;
    return a;
  endfunction

  task automatic step(input int rd_pct, input int wr_pct, input int rdy_pct);
    int sel;
    bit hit;
    logic [DW-1:0] hd;
    bit e_rdy_r, e_rdy_w, fire;
    logic [AW-1:0] ra;
    @(negedge clk);
    rd_in_valid = ($urandom % 100) < rd_pct;
    rd_in_addr  = gen_addr();
    wr_in_valid = ($urandom % 100) < wr_pct;
    wr_in_addr  = gen_addr();
    wr_in_data  = $urandom;
    bus_ready   = ($urandom % 100) < rdy_pct;
    #1;
    // expected outputs from model state
    if (m_lock != 0) sel = m_lock;
    else if (m_wa.size() > 0 && (m_rq.size() == 0 || m_wa.size() == WQD)) sel = 2;
    else if (m_rq.size() > 0) sel = 1;
    else sel = 0;
    hit = 1'b0; hd = '0;
    ra = rd_in_addr;
    foreach (m_wa[i]) if ((m_wa[i] >> LSB) == (ra >> LSB)) begin hit = 1'b1; hd = m_wd[i]; end
    e_rdy_r = hit || (m_rq.size() < RQD);
    e_rdy_w = (m_wa.size() < WQD);
    chk("R1/R6 rd_in_ready", 64'(rd_in_ready), 64'(e_rdy_r));
    chk("R2 wr_in_ready", 64'(wr_in_ready), 64'(e_rdy_w));
    chk("R4 bus_valid", 64'(bus_valid), 64'(sel != 0));
    if (sel != 0) begin
      chk("R3 bus_is_write", 64'(bus_is_write), 64'(sel == 2));
      chk("R8 R9 bus_addr", 64'(bus_addr), 64'(sel == 2 ? m_wa[0] : m_rq[0]));
      if (sel == 2) chk("R9 bus_wdata", 64'(bus_wdata), 64'(m_wd[0]));
    end
    chk("R5/R7 hit_valid", 64'(hit_valid), 64'(m_hv));
    if (m_hv) chk("R5 hit_data", 64'(hit_data), 64'(m_hd));
    // advance model
    fire = (sel != 0) && bus_ready;
    m_hv = rd_in_valid && hit;
    if (rd_in_valid && hit) m_hd = hd;
    if (fire && sel == 1) void'(m_rq.pop_front());
    if (fire && sel == 2) begin void'(m_wa.pop_front()); void'(m_wd.pop_front()); end
    if (rd_in_valid && !hit && e_rdy_r) m_rq.push_back(rd_in_addr);
    if (wr_in_valid && e_rdy_w) begin m_wa.push_back(wr_in_addr); m_wd.push_back(wr_in_data); end
    m_lock = ((sel != 0) && !bus_ready) ? sel : 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 bus_valid", 64'(bus_valid), 64'd0);
    chk("R10 hit_valid", 64'(hit_valid), 64'd0);
    chk("R10 rd_in_ready", 64'(rd_in_ready), 64'd1);
    chk("R10 wr_in_ready", 64'(wr_in_ready), 64'd1);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      case ((c / 500) % 4)
        0: step(50, 50, 90);
        1: step(60, 70, 15);   // stalled bus: queues fill, full-drain path
        2: step(10, 80, 50);   // write heavy
        default: step(70, 40, 50);
      endcase
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule